// File: doc/BRIEF.md
# RTC Register Write Lockout Controller

This block decides when the host bus and the on-chip microcontroller may write the real-time-clock and CMOS RAM registers. It watches digital supply-status flags from external comparators (main supply good, standby supply good, battery newly installed), the PowerGood input and the microcontroller's init-busy flag. It gates each write strobe with that requester's own lockout. Reads are never touched, so read strobes do not pass through it.

After the main supply returns, the host stays locked out for a timed window of `LOCK_CYCLES` reference clocks. By default this is 750 µs at 50 MHz, which lies inside the required 0.5 ms to 1 ms band. The window is only applied while the divider-chain field selects normal running (`010`) and the VRT bit is set. When the main supply returns while the microcontroller is itself still locked out, the host also waits for that lockout to end, so the host is released only after both conditions have cleared. The block also drives the oscillator enable, and it raises a one-cycle register-clear strobe when a battery was installed while the standby supply was absent and the standby supply then returns.

All five status flags are asynchronous and pass through two-flop synchronizers. The block has no data path: every pin is plain control or status, with no valid/ready handshake, and nothing at its edge can stall.

Top module: `rtc_wr_guard`

## Requirements
- R1: While the synchronized main-supply flag is 0, `host_lock_o` is 1 and `host_wr_o` is 0.
- R2: While the main supply is good but PowerGood is 0, `host_lock_o` is 1.
- R3: When the main-supply flag rises with `div_ctl_i` = 3'b010 and `vrt_i` = 1, the host stays locked for `LOCK_CYCLES` clocks after the risen flag first appears on the output side of the synchronizer. If the flag drops during the window, the window is abandoned, and the next rise starts a full new window.
- R4: When `div_ctl_i` is not 3'b010 or `vrt_i` is 0, no timed window is applied. Making either condition true during a window ends the window on the next clock.
- R5: `mcu_lock_o` is 1 while the standby-supply flag is 0, or while the flag is 1 and `mcu_init_i` is 1.
- R6: If the main-supply flag rises while `mcu_lock_o` is 1, the host stays locked until both the timed window and the microcontroller lockout have ended. If both end on the same clock, the host is released on that clock.
- R7: `host_wr_o` = `host_wr_i` AND NOT `host_lock_o`, and `mcu_wr_o` = `mcu_wr_i` AND NOT `mcu_lock_o`. A blocked write produces no strobe.
- R8: `osc_en_o` is 0 while `div_ctl_i` is 3'b000 or 3'b001.
- R9: A battery-install flag seen while the standby supply is absent forces `osc_en_o` to 0 until the standby supply returns.
- R10: When the standby supply returns after such a battery install, `reg_clr_o` is high for exactly one clock. A battery-install flag seen while the standby supply is present has no effect.
- R11: A change on any status flag reaches the lockout outputs two clock edges later.
- R12: During reset, both lockouts are 1, both write strobes are 0 and `reg_clr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the lockout timer |
| rst_n | input | 1 | Asynchronous reset, active low |
| main_ok_i | input | 1 | Main supply above threshold (asynchronous) |
| stby_ok_i | input | 1 | Standby supply above threshold (asynchronous) |
| bat_new_i | input | 1 | Battery newly installed (asynchronous) |
| pwr_good_i | input | 1 | PowerGood (asynchronous) |
| mcu_init_i | input | 1 | Microcontroller in hardware init (asynchronous) |
| div_ctl_i | input | 3 | Divider-chain control field |
| vrt_i | input | 1 | VRT bit |
| host_wr_i | input | 1 | Host write strobe request |
| mcu_wr_i | input | 1 | Microcontroller write strobe request |
| host_wr_o | output | 1 | Gated host write strobe |
| mcu_wr_o | output | 1 | Gated microcontroller write strobe |
| host_lock_o | output | 1 | Host lockout active |
| mcu_lock_o | output | 1 | Microcontroller lockout active |
| osc_en_o | output | 1 | Oscillator enable |
| reg_clr_o | output | 1 | One-cycle clear strobe for registers 00h to 0Dh |

## Verification
The timed host window can expire on the same clock on which the microcontroller lockout drops. Both are release conditions for the host, and a fault in how they are combined shows up either as an early unlock or as an extra cycle of lockout. The bench brings both supplies up together with init held, then drops init so that its synchronized edge lands exactly on the window's last clock. It checks that the host is still locked one cycle before that clock and that both requesters are free on it.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;

  typedef struct packed {
    logic main_ok;
    logic stby_ok;
    logic bat_new;
    logic pwr_good;
    logic mcu_init;
  } supply_stat_t;

  localparam int STAT_W = $bits(supply_stat_t);

  // divider field value for normal running
  localparam logic [2:0] DIV_RUN = 3'b010;

  function automatic logic div_stops_osc(input logic [2:0] d);
    return (d[2:1] == 2'b00);
  endfunction

endpackage

// File: rtl/rtc_guard_sync.sv
module rtc_guard_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rtc_guard_timer.sv
module rtc_guard_timer #(
  parameter int unsigned LOCK_CYCLES = 37500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_ok,
  input  logic bypass,
  output logic rise,
  output logic start,
  output logic busy
);
  localparam int unsigned CW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic          prev_q;
  logic [CW-1:0] cnt_q;

  assign rise  = main_ok & ~prev_q;
  assign start = rise & ~bypass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      busy   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= main_ok;
      if (!main_ok || bypass) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else if (start) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (busy) begin
        if (cnt_q == LAST) begin
          busy  <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && main_ok && !bypass && cnt_q != LAST) |=> busy);

  // R4
  bypass_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> !busy);

endmodule

// File: rtl/rtc_guard_access.sv
module rtc_guard_access (
  input  logic clk,
  input  logic rst_n,
  input  logic main_ok,
  input  logic stby_ok,
  input  logic pwr_good,
  input  logic mcu_init,
  input  logic win_rise,
  input  logic win_start,
  input  logic win_busy,
  input  logic host_req,
  input  logic mcu_req,
  output logic host_lock,
  output logic mcu_lock,
  output logic host_wen,
  output logic mcu_wen
);
  logic join_q;

  assign mcu_lock = ~stby_ok | mcu_init;

  // host also waits for the microcontroller when main came up under its lockout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) join_q <= 1'b0;
    else        join_q <= main_ok & mcu_lock & (join_q | win_rise);
  end

  assign host_lock = ~main_ok | ~pwr_good | win_busy | win_start
                   | ((join_q | win_rise) & mcu_lock);

  assign host_wen = host_req & ~host_lock;
  assign mcu_wen  = mcu_req & ~mcu_lock;

  // R7
  host_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wen |-> (main_ok && pwr_good && !win_busy));

  // R5
  mcu_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mcu_wen |-> (stby_ok && !mcu_init));

  // R6
  join_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (join_q && !stby_ok) |-> !host_wen);

endmodule

// File: rtl/rtc_guard_osc.sv
module rtc_guard_osc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] div_ctl,
  input  logic       stby_ok,
  input  logic       bat_new,
  output logic       osc_en,
  output logic       reg_clr
);
  import rtc_guard_pkg::*;

  logic kill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kill_q  <= 1'b0;
      reg_clr <= 1'b0;
    end else begin
      reg_clr <= kill_q & stby_ok;
      if (bat_new && !stby_ok) kill_q <= 1'b1;
      else if (stby_ok)        kill_q <= 1'b0;
    end
  end

  assign osc_en = ~div_stops_osc(div_ctl) & ~kill_q;

  // R10
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_clr |=> !reg_clr);

  // R9
  kill_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_new && !stby_ok) |=> !osc_en);

  // R10
  clr_needs_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_clr |-> $past(stby_ok));

endmodule

// File: rtl/rtc_wr_guard.sv
module rtc_wr_guard #(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned LOCK_US     = 750,
  parameter int unsigned LOCK_CYCLES = (CLK_HZ / 1_000_000) * LOCK_US,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_ok_i,
  input  logic       stby_ok_i,
  input  logic       bat_new_i,
  input  logic       pwr_good_i,
  input  logic       mcu_init_i,
  input  logic [2:0] div_ctl_i,
  input  logic       vrt_i,
  input  logic       host_wr_i,
  input  logic       mcu_wr_i,
  output logic       host_wr_o,
  output logic       mcu_wr_o,
  output logic       host_lock_o,
  output logic       mcu_lock_o,
  output logic       osc_en_o,
  output logic       reg_clr_o
);
  import rtc_guard_pkg::*;

  supply_stat_t     raw_s, syn_s;
  logic [STAT_W-1:0] syn_v;
  logic bypass, w_rise, w_start, w_busy;

  assign raw_s = '{main_ok: main_ok_i, stby_ok: stby_ok_i, bat_new: bat_new_i,
                   pwr_good: pwr_good_i, mcu_init: mcu_init_i};

  rtc_guard_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_s), .q(syn_v)
  );
  assign syn_s = supply_stat_t'(syn_v);

  assign bypass = (div_ctl_i != DIV_RUN) | ~vrt_i;

  rtc_guard_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .main_ok(syn_s.main_ok), .bypass(bypass),
    .rise(w_rise), .start(w_start), .busy(w_busy)
  );

  rtc_guard_access u_access (
    .clk(clk), .rst_n(rst_n),
    .main_ok(syn_s.main_ok), .stby_ok(syn_s.stby_ok),
    .pwr_good(syn_s.pwr_good), .mcu_init(syn_s.mcu_init),
    .win_rise(w_rise), .win_start(w_start), .win_busy(w_busy),
    .host_req(host_wr_i), .mcu_req(mcu_wr_i),
    .host_lock(host_lock_o), .mcu_lock(mcu_lock_o),
    .host_wen(host_wr_o), .mcu_wen(mcu_wr_o)
  );

  rtc_guard_osc u_osc (
    .clk(clk), .rst_n(rst_n), .div_ctl(div_ctl_i),
    .stby_ok(syn_s.stby_ok), .bat_new(syn_s.bat_new),
    .osc_en(osc_en_o), .reg_clr(reg_clr_o)
  );

  // R1
  main_low_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !syn_s.main_ok |-> (host_lock_o && !host_wr_o));

  // R2
  pg_low_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !syn_s.pwr_good |-> host_lock_o);

endmodule

// File: tb/sim_rtc_wr_guard.sv
module sim_rtc_wr_guard;
  localparam int unsigned NWIN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_ok = 0, stby_ok = 0, bat_new = 0, pwr_good = 0, mcu_init = 0;
  logic [2:0] div_ctl = 3'b010;
  logic vrt = 0, host_wr = 1, mcu_wr = 1;
  logic host_wr_o, mcu_wr_o, host_lock_o, mcu_lock_o, osc_en_o, reg_clr_o;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  rtc_wr_guard #(.LOCK_CYCLES(NWIN)) u0 (
    .clk(clk), .rst_n(rst_n), .main_ok_i(main_ok), .stby_ok_i(stby_ok),
    .bat_new_i(bat_new), .pwr_good_i(pwr_good), .mcu_init_i(mcu_init),
    .div_ctl_i(div_ctl), .vrt_i(vrt), .host_wr_i(host_wr), .mcu_wr_i(mcu_wr),
    .host_wr_o(host_wr_o), .mcu_wr_o(mcu_wr_o), .host_lock_o(host_lock_o),
    .mcu_lock_o(mcu_lock_o), .osc_en_o(osc_en_o), .reg_clr_o(reg_clr_o)
  );

  // {main,stby,pg,init,div[2:0],vrt,hreq,mreq, exp_host_wr,exp_mcu_wr,exp_osc}
  localparam logic [12:0] VEC [10] = '{
    13'b0_1_1_0_010_0_1_1_0_1_1,
    13'b1_1_1_0_010_0_1_1_1_1_1,
    13'b1_1_0_0_011_0_1_1_0_1_1,
    13'b1_1_1_1_100_0_1_1_1_0_1,
    13'b1_1_1_0_000_0_1_1_1_1_0,
    13'b1_1_1_0_001_0_1_0_1_0_0,
    13'b1_0_1_0_111_0_0_1_0_0_1,
    13'b0_0_1_0_010_0_1_1_0_0_1,
    13'b0_1_1_0_110_0_1_1_0_1_1,
    13'b1_1_1_0_101_0_1_1_1_1_1
  };

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic all_up();
    main_ok = 1; stby_ok = 1; pwr_good = 1; mcu_init = 0; bat_new = 0;
    div_ctl = 3'b010; vrt = 0; host_wr = 1; mcu_wr = 1;
    tk(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pulses;
    // R12 reset state
    tk(3);
    chk("R12 host_lock", host_lock_o, 1'b1);
    chk("R12 mcu_lock", mcu_lock_o, 1'b1);
    chk("R12 host_wr", host_wr_o, 1'b0);
    chk("R12 mcu_wr", mcu_wr_o, 1'b0);
    chk("R12 reg_clr", reg_clr_o, 1'b0);
    rst_n = 1;
    tk(2);

    // vector table: R1 R2 R5 R7 R8
    for (int i = 0; i < 10; i++) begin
      {main_ok, stby_ok, pwr_good, mcu_init, div_ctl, vrt, host_wr, mcu_wr} = VEC[i][12:3];
      tk(3);
      chk("R7/R1/R2 host_wr vec", host_wr_o, VEC[i][2]);
      chk("R7/R5 mcu_wr vec", mcu_wr_o, VEC[i][1]);
      chk("R8 osc vec", osc_en_o, VEC[i][0]);
    end

    // R3 timed window
    all_up();
    main_ok = 0; tk(3);
    chk("R1 main low", host_lock_o, 1'b1);
    vrt = 1; main_ok = 1;
    tk(NWIN + 2);
    chk("R3 last locked", host_lock_o, 1'b1);
    chk("R7 blocked write", host_wr_o, 1'b0);
    tk(1);
    chk("R3 released", host_lock_o, 1'b0);
    chk("R7 write passes", host_wr_o, 1'b1);

    // R11 + R4 bypass via vrt
    all_up();
    main_ok = 0; tk(1);
    chk("R11 one edge", host_lock_o, 1'b0);
    tk(1);
    chk("R11 two edges", host_lock_o, 1'b1);
    tk(1);
    main_ok = 1; tk(1);
    chk("R11 rise one edge", host_lock_o, 1'b1);
    tk(1);
    chk("R4 vrt0 no window", host_lock_o, 1'b0);

    // R4 bypass via divider
    main_ok = 0; tk(3);
    div_ctl = 3'b011; vrt = 1; main_ok = 1; tk(2);
    chk("R4 div bypass", host_lock_o, 1'b0);

    // R4 bypass raised mid window
    all_up();
    main_ok = 0; tk(3);
    vrt = 1; main_ok = 1; tk(8);
    chk("R3 mid window", host_lock_o, 1'b1);
    vrt = 0; tk(1);
    chk("R4 mid bypass", host_lock_o, 1'b0);

    // R3 main drop mid window restarts full window
    all_up();
    main_ok = 0; tk(3);
    vrt = 1; main_ok = 1; tk(10);
    main_ok = 0; tk(3);
    chk("R1 drop in window", host_lock_o, 1'b1);
    main_ok = 1; tk(NWIN + 2);
    chk("R3 restart locked", host_lock_o, 1'b1);
    tk(1);
    chk("R3 restart released", host_lock_o, 1'b0);

    // R6 init outlasts window
    all_up();
    main_ok = 0; stby_ok = 0; tk(3);
    vrt = 1; main_ok = 1; stby_ok = 1; mcu_init = 1;
    tk(30);
    chk("R6 host waits init", host_lock_o, 1'b1);
    chk("R5 mcu in init", mcu_lock_o, 1'b1);
    mcu_init = 0; tk(1);
    chk("R6 host still", host_lock_o, 1'b1);
    tk(1);
    chk("R6 host freed", host_lock_o, 1'b0);
    chk("R5 mcu freed", mcu_lock_o, 1'b0);

    // R6 window and init end on the same clock
    all_up();
    main_ok = 0; stby_ok = 0; tk(3);
    vrt = 1; main_ok = 1; stby_ok = 1; mcu_init = 1;
    tk(NWIN + 1);
    mcu_init = 0;
    tk(1);
    chk("R6 same-cycle before", host_lock_o, 1'b1);
    tk(1);
    chk("R6 same-cycle host", host_lock_o, 1'b0);
    chk("R6 same-cycle mcu", mcu_lock_o, 1'b0);

    // R2 PowerGood after window
    pwr_good = 0; tk(2);
    chk("R2 pg low", host_lock_o, 1'b1);
    pwr_good = 1; tk(2);
    chk("R2 pg back", host_lock_o, 1'b0);

    // R9 R10 battery install without standby
    all_up();
    stby_ok = 0; tk(3);
    chk("R5 stby low", mcu_lock_o, 1'b1);
    bat_new = 1; tk(3);
    chk("R9 osc killed", osc_en_o, 1'b0);
    bat_new = 0; tk(5);
    chk("R9 osc stays off", osc_en_o, 1'b0);
    chk("R10 no clr yet", reg_clr_o, 1'b0);
    stby_ok = 1; tk(2);
    chk("R10 clr not early", reg_clr_o, 1'b0);
    tk(1);
    chk("R10 clr pulse", reg_clr_o, 1'b1);
    chk("R9 osc back", osc_en_o, 1'b1);
    pulses = 0;
    for (int k = 0; k < 10; k++) begin
      tk(1);
      if (reg_clr_o) pulses++;
    end
    chk("R10 single cycle", pulses == 0, 1'b1);

    // R10 battery flag with standby present is ignored
    bat_new = 1;
    pulses = 0;
    for (int k = 0; k < 6; k++) begin
      tk(1);
      if (reg_clr_o) pulses++;
    end
    chk("R10 ignored clr", pulses == 0, 1'b1);
    chk("R10 ignored osc", osc_en_o, 1'b1);
    bat_new = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule